// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration-space front end of a peripheral hub that sits on a byte-wide I/O bus with two addresses. The low address is the base and the high address is base+1. After reset the port is closed. A host opens it by writing a two-byte key to the base address. While the port is open, a byte written to the base selects a register index. Reads and writes at base+1 then reach the register that index names. A dedicated byte written to the base closes the port again.

Registers below 0x30 are global and live in this block. They are the logical-device selector at 0x07, a read-only chip identity at 0x20, and four pin-routing bytes at 0x29, 0x2B, 0x2C and 0x2D. One of these routes the watchdog output to a package pin. Registers at 0x30 and above are banked by the selected logical device. Register 0x30 holds each device's activation bit and is kept here. Every other banked index is forwarded to the devices behind the port as a one-cycle read or write strobe. The strobe carries the index, the device number and the write data, and a banked read takes the device's reply. Every read completes two cycles after it is issued, so the host sees one fixed latency for all read sources.

Top module: `sio_cfg_port`

## Requirements
- R1: The port opens only after 0x87 is written to the base twice with no other base write between them. A base write of any other byte while the port is closed restarts the key.
- R2: While the port is closed, writes to base+1 change no register and raise no strobe. Reads of either address return 0xFF.
- R3: While the port is open, writing 0xAA to the base closes it. Any other base byte loads the index register, and a read of the base returns the index. The index is kept across a close and reopen.
- R4: After reset the port is closed, the index and device number are 0x00, every activation bit is clear, pin_mux equals MUX_RST (default 0x2B = 0x10, the others 0x00), and rd_valid, the strobes and bus_rdata are 0.
- R5: A read asserted for one cycle gives rd_valid high for exactly one cycle, two clock edges later, with the read data on bus_rdata in that same cycle.
- R6: Index 0x07 is read/write. It holds the logical device number, which is driven on ld_num.
- R7: Index 0x20 always reads CHIP_ID (default 0x52), and writes to it have no effect.
- R8: Indices 0x29, 0x2B, 0x2C and 0x2D are read/write and appear on pin_mux as bytes {0x2D, 0x2C, 0x2B, 0x29} (0x29 in bits 7:0). wdog_pin_en is 1 exactly when bit 4 of 0x2B is 0. Any other index below 0x30 except 0x07 reads 0x00 and ignores writes.
- R9: Index 0x30 holds one activation bit (bit 0) per device below NUM_LD, shown on ld_active[n] and read back as {7'b0, bit}. With a device number at or above NUM_LD it reads 0x00 and ignores writes. Accesses to 0x30 raise no strobe.
- R10: A write to base+1 while open with an index above 0x30 raises ld_wr_stb for one cycle, one edge after the access. During that cycle ld_idx, ld_num and ld_wdata hold the index, device number and byte.
- R11: A read of base+1 while open with an index above 0x30 raises ld_rd_stb for one cycle, one edge after the access. The ld_rdata value present in that cycle is returned as the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the base address, 1 selects base+1 |
| bus_wr | input | 1 | Write access this cycle |
| bus_rd | input | 1 | Read access this cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while rd_valid is high |
| rd_valid | output | 1 | Read data valid, two cycles after bus_rd |
| ld_wr_stb | output | 1 | Banked register write strobe to the devices |
| ld_rd_stb | output | 1 | Banked register read strobe to the devices |
| ld_num | output | 8 | Selected logical device number |
| ld_idx | output | 8 | Current register index |
| ld_wdata | output | 8 | Byte of the last banked write |
| ld_rdata | input | 8 | Device reply, sampled while ld_rd_stb is high |
| ld_active | output | NUM_LD | Activation bit of each logical device |
| pin_mux | output | 32 | Pin-routing bytes {0x2D, 0x2C, 0x2B, 0x29} |
| wdog_pin_en | output | 1 | Watchdog output routed to its pin |

## Verification
The checker assumes that bus_rd and bus_wr are never high in the same cycle, and that both stay low while rst is asserted. The read-latency, locked-read and device-number properties count cycles back to the access and rely on that. The bench issues one access per task call, separated by an idle cycle. It never overlaps a read with a write, and it holds the strobes low during reset. The device model answers ld_rdata combinationally from ld_idx and ld_num, so a banked read is fully decided within the strobe cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] BANK_BASE  = 8'h30;
  localparam int         MUX_REGS   = 4;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_t;

  // index of each pin-routing byte, slot 0 lands in pin_mux[7:0]
  function automatic logic [7:0] mux_index(input int slot);
    case (slot)
      0:       return 8'h29;
      1:       return 8'h2B;
      2:       return 8'h2C;
      default: return 8'h2D;
    endcase
  endfunction
endpackage

// File: rtl/sio_key_lock.sv
module sio_key_lock
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       base_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  lock_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LK_CLOSED;
    end else if (base_wr) begin
      case (st)
        LK_CLOSED: st <= (wdata == KEY_ENTER) ? LK_HALF : LK_CLOSED;
        LK_HALF:   st <= (wdata == KEY_ENTER) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   if (wdata == KEY_EXIT) st <= LK_CLOSED;
        default:   st <= LK_CLOSED;
      endcase
    end
  end

  assign unlocked = (st == LK_OPEN);
endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
  import sio_pkg::*;
#(
  parameter logic [7:0]  CHIP_ID = 8'h52,
  parameter logic [31:0] MUX_RST = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_val,
  output logic [7:0]  ldn,
  output logic [31:0] mux
);
  localparam int MW = 8 * MUX_REGS;

  logic [MW-1:0]       mux_q;
  logic [MUX_REGS-1:0] mux_hit;

  always_ff @(posedge clk) begin
    if (rst)                          ldn <= 8'h00;
    else if (wr_en && idx == IDX_LDN) ldn <= wdata;
  end

  for (genvar g = 0; g < MUX_REGS; g++) begin : g_mux
    localparam logic [7:0] MY_IDX = mux_index(g);
    assign mux_hit[g] = (idx == MY_IDX);
    always_ff @(posedge clk) begin
      if (rst)                     mux_q[8*g +: 8] <= MUX_RST[8*g +: 8];
      else if (wr_en && mux_hit[g]) mux_q[8*g +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (idx == IDX_LDN)    rd_val = ldn;
    if (idx == IDX_CHIPID) rd_val = CHIP_ID;
    for (int s = 0; s < MUX_REGS; s++)
      if (mux_hit[s]) rd_val = mux_q[8*s +: 8];
  end

  assign mux = mux_q;
endmodule

// File: rtl/sio_act_bank.sv
module sio_act_bank #(
  parameter int NUM_LD = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        ldn,
  input  logic              wbit,
  output logic [NUM_LD-1:0] active,
  output logic              rd_bit
);
  for (genvar g = 0; g < NUM_LD; g++) begin : g_act
    localparam logic [7:0] MY_LDN = 8'(g);
    always_ff @(posedge clk) begin
      if (rst)                          active[g] <= 1'b0;
      else if (wr_en && ldn == MY_LDN)  active[g] <= wbit;
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int n = 0; n < NUM_LD; n++)
      if (ldn == 8'(n)) rd_bit = active[n];
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_pkg::*;
#(
  parameter int          NUM_LD  = 16,
  parameter logic [7:0]  CHIP_ID = 8'h52,
  parameter logic [31:0] MUX_RST = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rd_valid,
  output logic              ld_wr_stb,
  output logic              ld_rd_stb,
  output logic [7:0]        ld_num,
  output logic [7:0]        ld_idx,
  output logic [7:0]        ld_wdata,
  input  logic [7:0]        ld_rdata,
  output logic [NUM_LD-1:0] ld_active,
  output logic [31:0]       pin_mux,
  output logic              wdog_pin_en
);
  localparam int WDOG_MUX_BIT = 8 + 4;  // bit 4 of the 0x2B byte

  logic       unlocked;
  logic [7:0] idx_q;
  logic [7:0] glob_rd;
  logic       act_rd;
  logic       rd_p1;
  logic [7:0] rd_hold;

  wire base_wr = bus_wr & ~bus_addr;
  wire data_wr = bus_wr & bus_addr & unlocked;
  wire data_rd = bus_rd & bus_addr & unlocked;
  wire banked  = (idx_q >= BANK_BASE);
  wire is_act  = (idx_q == IDX_ACT);
  wire dev_reg = banked & ~is_act;

  sio_key_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .base_wr  (base_wr),
    .wdata    (bus_wdata),
    .unlocked (unlocked)
  );

  sio_glob_regs #(.CHIP_ID(CHIP_ID), .MUX_RST(MUX_RST)) u_glob (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (data_wr & ~banked),
    .idx    (idx_q),
    .wdata  (bus_wdata),
    .rd_val (glob_rd),
    .ldn    (ld_num),
    .mux    (pin_mux)
  );

  sio_act_bank #(.NUM_LD(NUM_LD)) u_act (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (data_wr & is_act),
    .ldn    (ld_num),
    .wbit   (bus_wdata[0]),
    .active (ld_active),
    .rd_bit (act_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= 8'h00;
    else if (base_wr && unlocked && bus_wdata != KEY_EXIT)
      idx_q <= bus_wdata;
  end

  // stage 1: strobes to the devices and local read value
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1     <= 1'b0;
      rd_hold   <= 8'h00;
      ld_wr_stb <= 1'b0;
      ld_rd_stb <= 1'b0;
      ld_wdata  <= 8'h00;
    end else begin
      rd_p1     <= bus_rd;
      ld_wr_stb <= data_wr & dev_reg;
      ld_rd_stb <= data_rd & dev_reg;
      if (data_wr & dev_reg) ld_wdata <= bus_wdata;
      if (bus_rd) begin
        if (!unlocked)     rd_hold <= 8'hFF;
        else if (!bus_addr) rd_hold <= idx_q;
        else if (!banked)  rd_hold <= glob_rd;
        else if (is_act)   rd_hold <= {7'b0, act_rd};
        else               rd_hold <= 8'h00;
      end
    end
  end

  // stage 2: return data, device reply taken during its strobe cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      rd_valid <= rd_p1;
      if (rd_p1) bus_rdata <= ld_rd_stb ? ld_rdata : rd_hold;
    end
  end

  assign ld_idx      = idx_q;
  assign wdog_pin_en = ~pin_mux[WDOG_MUX_BIT];
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rd_valid,
  input logic       ld_wr_stb,
  input logic       ld_rd_stb,
  input logic [7:0] ld_num,
  input logic       unlocked
);
  // R1
  unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

  // R2
  locked_wr_chk: assert property (@(posedge clk) disable iff (rst)
    ld_wr_stb |-> $past(unlocked && bus_wr && bus_addr));

  // R2
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(!unlocked, 2)) |-> bus_rdata == 8'hFF);

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd, 2));

  // R6
  ldn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr && bus_addr) |-> $stable(ld_num));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_wr_stb && ld_rd_stb));

  // R11
  rd_stb_src_chk: assert property (@(posedge clk) disable iff (rst)
    ld_rd_stb |-> $past(unlocked && bus_rd && bus_addr));
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rd_valid  (rd_valid),
  .ld_wr_stb (ld_wr_stb),
  .ld_rd_stb (ld_rd_stb),
  .ld_num    (ld_num),
  .unlocked  (unlocked)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int NUM_LD = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_addr = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [7:0]        bus_wdata = 8'h00;
  logic [7:0]        bus_rdata;
  logic              rd_valid;
  logic              ld_wr_stb, ld_rd_stb;
  logic [7:0]        ld_num, ld_idx, ld_wdata, ld_rdata;
  logic [NUM_LD-1:0] ld_active;
  logic [31:0]       pin_mux;
  logic              wdog_pin_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic [7:0] exp; string req; } sb_item_t;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  // device model: reply derived from the forwarded index and device number
  assign ld_rdata = ld_idx ^ ld_num ^ 8'h3C;

  sio_cfg_port #(.NUM_LD(NUM_LD)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
    .ld_wr_stb(ld_wr_stb), .ld_rd_stb(ld_rd_stb), .ld_num(ld_num), .ld_idx(ld_idx),
    .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .ld_active(ld_active),
    .pin_mux(pin_mux), .wdog_pin_en(wdog_pin_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input bit dev_stb, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a) check(ld_wr_stb == dev_stb, req, 32'(ld_wr_stb), 32'(dev_stb));
  endtask

  task automatic bus_read(input logic a, input logic [7:0] exp, input bit dev_stb, input string req);
    sb_item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
    check(ld_rd_stb == dev_stb, req, 32'(ld_rd_stb), 32'(dev_stb));
  endtask

  task automatic open_port();
    bus_write(1'b0, 8'h87, 1'b0, "R1");
    bus_write(1'b0, 8'h87, 1'b0, "R1");
  endtask

  // monitor: pops the expected read data when the design presents it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5 unexpected rd_valid", 32'(bus_rdata), 32'h0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(bus_rdata == it.exp, it.req, 32'(bus_rdata), 32'(it.exp));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    check(rd_valid == 1'b0 && bus_rdata == 8'h00, "R4 read outputs", {bus_rdata, 7'b0, rd_valid}, 32'h0);
    check(!ld_wr_stb && !ld_rd_stb, "R4 strobes", {ld_wr_stb, ld_rd_stb}, 32'h0);
    check(ld_num == 8'h00 && ld_idx == 8'h00, "R4 index and device", {ld_num, ld_idx}, 32'h0);
    check(ld_active == '0, "R4 activation", 32'(ld_active), 32'h0);
    check(pin_mux == 32'h0000_1000 && !wdog_pin_en, "R4 pin mux", pin_mux, 32'h0000_1000);
    rst = 1'b0;

    // R2 closed port
    bus_read(1'b1, 8'hFF, 1'b0, "R2 closed data read");
    bus_read(1'b0, 8'hFF, 1'b0, "R2 closed base read");
    bus_write(1'b1, 8'h55, 1'b0, "R2 closed data write");

    // R1 broken key restarts
    bus_write(1'b0, 8'h87, 1'b0, "R1");
    bus_write(1'b0, 8'h12, 1'b0, "R1");
    bus_write(1'b0, 8'h87, 1'b0, "R1");
    bus_read(1'b1, 8'hFF, 1'b0, "R1 key restart keeps port closed");
    bus_write(1'b0, 8'h87, 1'b0, "R1");
    bus_read(1'b0, 8'h00, 1'b0, "R1 R4 opened, index reset value");

    // R7 chip identity
    bus_write(1'b0, 8'h20, 1'b0, "R3");
    bus_read(1'b0, 8'h20, 1'b0, "R3 index readback");
    bus_read(1'b1, 8'h52, 1'b0, "R7 chip id");
    bus_write(1'b1, 8'h11, 1'b0, "R7 write ignored");
    bus_read(1'b1, 8'h52, 1'b0, "R7 chip id after write");

    // R8 pin routing
    bus_write(1'b0, 8'h2B, 1'b0, "R3");
    bus_read(1'b1, 8'h10, 1'b0, "R8 reset value of 0x2B");
    bus_write(1'b1, 8'h00, 1'b0, "R8");
    check(wdog_pin_en == 1'b1, "R8 watchdog routed", 32'(wdog_pin_en), 32'h1);
    bus_write(1'b0, 8'h29, 1'b0, "R3");
    bus_write(1'b1, 8'h60, 1'b0, "R8");
    bus_write(1'b0, 8'h2D, 1'b0, "R3");
    bus_write(1'b1, 8'h01, 1'b0, "R8");
    check(pin_mux == 32'h0100_0060, "R8 pin_mux layout", pin_mux, 32'h0100_0060);
    bus_read(1'b1, 8'h01, 1'b0, "R8 0x2D readback");
    bus_write(1'b0, 8'h25, 1'b0, "R3");
    bus_write(1'b1, 8'h77, 1'b0, "R8 unused global write");
    bus_read(1'b1, 8'h00, 1'b0, "R8 unused global reads zero");

    // R6 device select
    bus_write(1'b0, 8'h07, 1'b0, "R3");
    bus_write(1'b1, 8'h08, 1'b0, "R6");
    check(ld_num == 8'h08, "R6 ld_num", 32'(ld_num), 32'h08);
    bus_read(1'b1, 8'h08, 1'b0, "R6 readback");

    // R9 activation
    bus_write(1'b0, 8'h30, 1'b0, "R3");
    bus_write(1'b1, 8'h01, 1'b0, "R9 no strobe on 0x30");
    check(ld_active == 16'h0100, "R9 device 8 active", 32'(ld_active), 32'h0100);
    bus_read(1'b1, 8'h01, 1'b0, "R9 activation readback");

    // R10 forwarded write
    bus_write(1'b0, 8'hF5, 1'b0, "R3");
    bus_write(1'b1, 8'h02, 1'b1, "R10 write strobe");
    check({ld_idx, ld_num, ld_wdata} == 24'hF5_08_02, "R10 strobe payload", {ld_idx, ld_num, ld_wdata}, 32'hF50802);
    @(negedge clk);
    check(ld_wr_stb == 1'b0, "R10 strobe one cycle", 32'(ld_wr_stb), 32'h0);

    // R11 forwarded read: F6 ^ 08 ^ 3C = C2
    bus_write(1'b0, 8'hF6, 1'b0, "R3");
    bus_read(1'b1, 8'hC2, 1'b1, "R11 device reply");

    // R3 close, R2 ignore, reopen keeps index
    bus_write(1'b0, 8'h2B, 1'b0, "R3");
    bus_write(1'b0, 8'hAA, 1'b0, "R3");
    bus_read(1'b1, 8'hFF, 1'b0, "R3 closed by 0xAA");
    bus_write(1'b1, 8'hFF, 1'b0, "R2 closed write no strobe");
    check(pin_mux == 32'h0100_0060, "R2 closed write ignored", pin_mux, 32'h0100_0060);
    open_port();
    bus_read(1'b0, 8'h2B, 1'b0, "R3 index kept");
    bus_read(1'b1, 8'h00, 1'b0, "R2 0x2B unchanged");

    // R9 device number out of range
    bus_write(1'b0, 8'h07, 1'b0, "R3");
    bus_write(1'b1, 8'h1F, 1'b0, "R6");
    bus_write(1'b0, 8'h30, 1'b0, "R3");
    bus_write(1'b1, 8'h01, 1'b0, "R9 out of range no strobe");
    check(ld_active == 16'h0100, "R9 out of range ignored", 32'(ld_active), 32'h0100);
    bus_read(1'b1, 8'h00, 1'b0, "R9 out of range reads zero");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R5 all reads answered", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule